// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block sits between a processor load/store port and a slower word-wide memory port. It keeps a power-of-two number of lines. Each line holds several words, a valid flag, a dirty flag and the upper address bits (the tag) of the block it holds. A byte address is split into three fields. The lowest field is the byte-in-word offset. Above it sits the word within the line, then the line index, and the tag takes the remaining high bits. A lookup hits only when the indexed line is valid and its tag equals the tag field of the address.

A run-time input `wb_mode` picks the write policy. When it is 0, the cache writes through and does not allocate on a write miss: every store goes to memory as one word, and the cache copy is also updated if the line is present. When it is 1, the cache writes back and allocates on a write miss: a store that hits only updates the cache and marks the line dirty, and a store that misses first brings the line in.

A miss stalls the processor while the line is refilled word by word. If the line about to be replaced is dirty, all of its words go back to memory before the first refill read is issued. There is no victim buffer. The processor holds its request until `cpu_stall` is low at a clock edge. Two counters report how many accesses hit and how many missed.

Top module: `dmc_cache`

## Requirements
- R1: After reset no line is valid, `cpu_stall` and `mem_valid` are 0, and both counters read 0; the first access to any address therefore misses.
- R2: Byte address bits [1:0] are the byte offset (must be 0), bits [3:2] select the word in the line, bits [9:4] select one of 64 lines, and bits [31:10] form the tag; byte address 1200 uses line 11, and two addresses 1024 bytes apart evict each other.
- R3: A read hit completes in the cycle it is presented, with `cpu_stall` low and `cpu_rdata` equal to the last value stored at that address.
- R4: A read miss raises `cpu_stall`. The cache then issues 4 read beats at ascending word addresses from the line base, with `mem_last` set only on the fourth beat. After that the read completes with the correct word.
- R5: With `wb_mode`=0, a write hit raises `cpu_stall` until one memory write beat (with `mem_last`=1, address equal to the word address) is accepted; both memory and the cached word then hold the new value.
- R6: With `wb_mode`=0, a write miss issues exactly one memory write beat and no read beat, and leaves the line unallocated, so a following read of that address misses.
- R7: With `wb_mode`=1, a write hit completes in the cycle it is presented, issues no memory beat, leaves memory unchanged and marks the line dirty.
- R8: With `wb_mode`=1, a write miss refills the line (4 read beats) and then writes the word into the cache only, marking the line dirty.
- R9: Replacing a dirty line first writes all 4 of its words to memory at ascending addresses from the victim line base (mem_last on the fourth), before any refill read beat; replacing a clean line issues no write beat.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, the request (valid, direction and address) stays unchanged into the next cycle.
- R11: `hit_count` rises by one for each access served without a miss; `miss_count` rises by one for each access that missed, counted once even though the access completes after a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back with write allocate, 0 = write-through without allocate |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Request pending and not completing this cycle |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat at this edge |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_last | output | 1 | Final beat of a line transfer or the single write-through beat |
| mem_rdata | input | 32 | Read data, valid when a read beat is accepted |
| hit_count | output | 16 | Number of accesses that hit |
| miss_count | output | 16 | Number of accesses that missed |

## Verification
The bench aims at three kinds of access. The first is a store that lands on a line left dirty by an earlier write-back store and is then evicted. A design that cleared the dirty flag, or skipped the write-back, would leave stale words in memory. The second is a read that misses onto a dirty line while `mem_ready` stalls at random. A design that interleaved the refill reads with the victim writes, or let its address slip during a stall, would corrupt memory or return wrong data. The third is a write-through store that misses and is then read back. A design that allocated on that miss would show a refill burst and count a hit where a miss is due. The bench also covers the address 1200 and its 1024-byte alias. It also checks that a refill followed by a store counts as only one miss.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_THRU  = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
`timescale 1ns/1ps
// Splits the word part of a byte address into tag, line index and word-in-line.
module dmc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int BOFF_W = 2,
  parameter int WOFF_W = 2,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W - WOFF_W - BOFF_W
) (
  input  logic [ADDR_W-1:BOFF_W] waddr,
  output logic [TAG_W-1:0]       tag,
  output logic [IDX_W-1:0]       idx,
  output logic [WOFF_W-1:0]      word
);
  function automatic logic [WOFF_W-1:0] word_of(input logic [ADDR_W-1:BOFF_W] a);
    return a[BOFF_W +: WOFF_W];
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:BOFF_W] a);
    return a[BOFF_W+WOFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:BOFF_W] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  assign word = word_of(waddr);
  assign idx  = index_of(waddr);
  assign tag  = tag_of(waddr);
endmodule

// File: rtl/dmc_store.sv
`timescale 1ns/1ps
// Line storage: data words, tags, valid and dirty flags, all addressed by one index.
module dmc_store #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 6,
  parameter int WOFF_W = 2,
  localparam int LINES = 1 << IDX_W,
  localparam int LW    = 1 << WOFF_W,
  localparam int DEPTH = LINES * LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WOFF_W-1:0] lk_word,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic [WOFF_W-1:0] ev_word,
  output logic [DATA_W-1:0] ev_data,
  input  logic              wr_en,
  input  logic [WOFF_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              meta_fill,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic              dirty_set,
  input  logic              dirty_clr
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [TAG_W-1:0]  tags  [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;

  function automatic logic [IDX_W+WOFF_W-1:0] slot(input logic [IDX_W-1:0] i,
                                                   input logic [WOFF_W-1:0] w);
    return {i, w};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) words[slot(idx, wr_word)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (meta_fill) tags[idx] <= new_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (meta_fill) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_clr) dirty_q[idx] <= 1'b0;
      if (dirty_set) dirty_q[idx] <= 1'b1;
    end
  end

  assign lk_data  = words[slot(idx, lk_word)];
  assign ev_data  = words[slot(idx, ev_word)];
  assign lk_valid = valid_q[idx];
  assign lk_dirty = dirty_q[idx];
  assign lk_tag   = tags[idx];

  // R1: a line only becomes valid through a completed refill
  a_r1_valid_only_by_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lk_valid) && $stable(idx)) |-> $past(meta_fill));
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
// Sequencer: lookup outcome, victim write-back, refill and write-through beats.
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int WOFF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              wb_mode,
  input  logic              hit,
  input  logic              vic_dirty,
  input  logic              mem_ready,
  output dmc_state_e        state,
  output logic [WOFF_W-1:0] beat,
  output logic              mem_valid,
  output logic              mem_we,
  output logic              mem_last,
  output logic              fill_we,
  output logic              meta_fill,
  output logic              cpu_wr,
  output logic              dirty_set,
  output logic              dirty_clr,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              ev_hit,
  output logic              ev_miss
);
  dmc_state_e nxt;
  logic       refilled;
  logic       last_beat;

  assign last_beat = &beat;

  always_comb begin
    nxt       = state;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_last  = 1'b0;
    fill_we   = 1'b0;
    meta_fill = 1'b0;
    cpu_wr    = 1'b0;
    dirty_set = 1'b0;
    dirty_clr = 1'b0;
    cpu_done  = 1'b0;
    ev_hit    = 1'b0;
    ev_miss   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpu_req) begin
          if (hit) begin
            ev_hit = !refilled;
            if (!cpu_we || wb_mode) begin
              cpu_done  = 1'b1;
              cpu_wr    = cpu_we;
              dirty_set = cpu_we;
            end else begin
              nxt = ST_THRU;
            end
          end else begin
            ev_miss = 1'b1;
            if (cpu_we && !wb_mode) nxt = ST_THRU;
            else if (vic_dirty)     nxt = ST_EVICT;
            else                    nxt = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_last  = last_beat;
        if (mem_ready && last_beat) begin
          dirty_clr = 1'b1;
          nxt       = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_last  = last_beat;
        if (mem_ready) begin
          fill_we = 1'b1;
          if (last_beat) begin
            meta_fill = 1'b1;
            nxt       = ST_IDLE;
          end
        end
      end
      ST_THRU: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_last  = 1'b1;
        if (mem_ready) begin
          cpu_done = 1'b1;
          cpu_wr   = hit;
          nxt      = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign cpu_stall = cpu_req && !cpu_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= '0;
      refilled <= 1'b0;
    end else begin
      state <= nxt;
      if ((state == ST_EVICT || state == ST_FILL) && mem_ready) beat <= beat + 1'b1;
      if (meta_fill)     refilled <= 1'b1;
      else if (cpu_done) refilled <= 1'b0;
    end
  end

  // R4: a lookup miss always holds the processor
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cpu_req && !hit) |-> cpu_stall);

  // R3: a read hit never stalls
  a_r3_read_hit_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cpu_req && hit && !cpu_we) |-> !cpu_stall);
endmodule

// File: rtl/dmc_cache.sv
`timescale 1ns/1ps
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;

  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [WOFF_W-1:0] cpu_word;
  logic [DATA_W-1:0] lk_data, ev_data;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic              hit, vic_dirty;
  dmc_state_e        state;
  logic [WOFF_W-1:0] beat;
  logic              fill_we, meta_fill, cpu_wr, dirty_set, dirty_clr;
  logic              cpu_done, ev_hit, ev_miss;
  logic              st_wr_en;
  logic [WOFF_W-1:0] st_wr_word;
  logic [DATA_W-1:0] st_wr_data;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .BOFF_W(BOFF_W), .WOFF_W(WOFF_W), .IDX_W(IDX_W)
  ) u_split (
    .waddr(cpu_addr[ADDR_W-1:BOFF_W]),
    .tag  (cpu_tag),
    .idx  (cpu_idx),
    .word (cpu_word)
  );

  assign hit       = lk_valid && (lk_tag == cpu_tag);
  assign vic_dirty = lk_valid && lk_dirty;

  dmc_ctrl #(.WOFF_W(WOFF_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .wb_mode  (wb_mode),
    .hit      (hit),
    .vic_dirty(vic_dirty),
    .mem_ready(mem_ready),
    .state    (state),
    .beat     (beat),
    .mem_valid(mem_valid),
    .mem_we   (mem_we),
    .mem_last (mem_last),
    .fill_we  (fill_we),
    .meta_fill(meta_fill),
    .cpu_wr   (cpu_wr),
    .dirty_set(dirty_set),
    .dirty_clr(dirty_clr),
    .cpu_done (cpu_done),
    .cpu_stall(cpu_stall),
    .ev_hit   (ev_hit),
    .ev_miss  (ev_miss)
  );

  assign st_wr_en   = fill_we || cpu_wr;
  assign st_wr_word = fill_we ? beat : cpu_word;
  assign st_wr_data = fill_we ? mem_rdata : cpu_wdata;

  dmc_store #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (cpu_idx),
    .lk_word  (cpu_word),
    .lk_data  (lk_data),
    .lk_valid (lk_valid),
    .lk_dirty (lk_dirty),
    .lk_tag   (lk_tag),
    .ev_word  (beat),
    .ev_data  (ev_data),
    .wr_en    (st_wr_en),
    .wr_word  (st_wr_word),
    .wr_data  (st_wr_data),
    .meta_fill(meta_fill),
    .new_tag  (cpu_tag),
    .dirty_set(dirty_set),
    .dirty_clr(dirty_clr)
  );

  assign cpu_rdata = lk_data;

  always_comb begin
    mem_addr  = {cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
    mem_wdata = cpu_wdata;
    unique case (state)
      ST_EVICT: begin
        mem_addr  = {lk_tag, cpu_idx, beat, {BOFF_W{1'b0}}};
        mem_wdata = ev_data;
      end
      ST_FILL: mem_addr = {cpu_tag, cpu_idx, beat, {BOFF_W{1'b0}}};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (ev_hit)  hit_count  <= hit_count + 1'b1;
      if (ev_miss) miss_count <= miss_count + 1'b1;
    end
  end

  // R2: requests are word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[BOFF_W-1:0] == '0));

  // R9: refill never starts while the indexed line is still dirty
  a_r9_clean_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> !vic_dirty);

  // R10: an unaccepted beat is held
  a_r10_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R11: the hit counter only moves on a counted hit
  a_r11_hit_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> $past(ev_hit));
endmodule

// File: tb/dmc_cache_test.sv
`timescale 1ns/1ps
module dmc_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wb_mode, cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_valid, mem_ready, mem_we, mem_last;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] hit_count, miss_count;

  always #10 clk = ~clk;

  dmc_cache uut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_last(mem_last), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int vectors = 0;
  int fails = 0;
  logic [31:0] bmem  [4096];
  logic [31:0] truth [4096];
  bit rv [64];
  int rtag [64];
  bit rdirty [64];
  int nwr, nrd, exp_vic_base, exp_line_base, hit_exp, miss_exp;
  bit g_thru, order_bad, prev_pending, rdy_rand;
  logic [31:0] prev_addr, g_waddr;

  assign mem_rdata = bmem[mem_addr[13:2]];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: picks ready for the coming edge, then logs the beat it accepts
  always @(negedge clk) begin
    if (rdy_rand) mem_ready = ($urandom % 3) != 0;
    else          mem_ready = 1'b1;
    if (rst_n) begin
      if (prev_pending)
        check(mem_valid && mem_addr == prev_addr, "R10", "held beat", mem_addr, prev_addr);
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          if (nrd != 0) order_bad = 1'b1;
          if (g_thru) begin
            check(mem_addr == g_waddr, "R5", "through address", mem_addr, g_waddr);
            check(mem_last == 1'b1, "R5", "through last", {31'd0, mem_last}, 32'd1);
          end else begin
            check(mem_addr == exp_vic_base + 4 * nwr, "R9", "victim address",
                  mem_addr, exp_vic_base + 4 * nwr);
            check(mem_last == (nwr == 3), "R9", "victim last", {31'd0, mem_last},
                  {31'd0, nwr == 3});
          end
          bmem[mem_addr[13:2]] = mem_wdata;
          nwr++;
        end else begin
          check(mem_addr == exp_line_base + 4 * nrd, "R4", "refill address",
                mem_addr, exp_line_base + 4 * nrd);
          check(mem_last == (nrd == 3), "R4", "refill last", {31'd0, mem_last},
                {31'd0, nrd == 3});
          nrd++;
        end
      end
      prev_pending = mem_valid && !mem_ready;
      prev_addr    = mem_addr;
    end
  end

  // one processor access, checked against the behavioural line model
  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input bit mode);
    int w = int'(addr[13:2]);
    int idx = (int'(addr) / 16) % 64;
    int tg = int'(addr) / 1024;
    bit hit = rv[idx] && rtag[idx] == tg;
    bit vdirty = rv[idx] && rdirty[idx];
    int vbase = (rtag[idx] * 64 + idx) * 16;
    bit alloc = !hit && (!we || mode);
    int ew, er, cyc;
    logic [31:0] old = bmem[w];
    string rq;
    if (!we) rq = hit ? "R3" : "R4";
    else if (mode) rq = hit ? "R7" : "R8";
    else rq = hit ? "R5" : "R6";
    if (!hit && (!we || mode)) begin ew = vdirty ? 4 : 0; er = 4; end
    else if (we && !mode) begin ew = 1; er = 0; end
    else begin ew = 0; er = 0; end
    exp_vic_base = vbase; exp_line_base = int'(addr) & ~15;
    g_thru = we && !mode; g_waddr = addr;
    nwr = 0; nrd = 0; order_bad = 1'b0;
    wb_mode = mode; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_req = 1'b1;
    #1;
    check(cpu_stall == !(hit && (!we || mode)), rq, "first-cycle stall",
          {31'd0, cpu_stall}, {31'd0, !(hit && (!we || mode))});
    cyc = 0;
    while (cpu_stall && cyc < 400) begin
      @(negedge clk); #2; cyc++;
    end
    check(cyc < 400, rq, "access completes", cyc, 400);
    if (!we) check(cpu_rdata == truth[w], rq, "load data", cpu_rdata, truth[w]);
    @(posedge clk); #1;
    cpu_req = 1'b0;
    check(nwr == ew, vdirty ? "R9" : rq, "write beats", nwr, ew);
    check(nrd == er, rq, "read beats", nrd, er);
    check(!order_bad, "R9", "write-back before refill", {31'd0, order_bad}, 32'd0);
    if (alloc) begin
      if (vdirty)
        for (int k = 0; k < 4; k++)
          check(bmem[vbase/4 + k] == truth[vbase/4 + k], "R9", "victim word in memory",
                bmem[vbase/4 + k], truth[vbase/4 + k]);
      rv[idx] = 1'b1; rtag[idx] = tg; rdirty[idx] = 1'b0;
    end
    if (we) begin
      truth[w] = wd;
      if (mode) begin
        rdirty[idx] = 1'b1;
        check(bmem[w] == old, rq, "memory untouched", bmem[w], old);
      end else begin
        check(bmem[w] == wd, rq, "memory updated", bmem[w], wd);
      end
    end
    if (hit) hit_exp++; else miss_exp++;
    check(hit_count == 16'(hit_exp), "R11", "hit count", {16'd0, hit_count}, hit_exp);
    check(miss_count == 16'(miss_exp), "R11", "miss count", {16'd0, miss_count}, miss_exp);
    @(negedge clk); #2;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int h0, m0;
    for (int i = 0; i < 4096; i++) begin
      bmem[i]  = (i * 32'h01010101) ^ 32'hA5A50000;
      truth[i] = bmem[i];
    end
    for (int i = 0; i < 64; i++) begin rv[i] = 0; rtag[i] = 0; rdirty[i] = 0; end
    hit_exp = 0; miss_exp = 0; rdy_rand = 1'b0; prev_pending = 1'b0;
    nwr = 0; nrd = 0; g_thru = 0; order_bad = 0; g_waddr = 0;
    exp_vic_base = 0; exp_line_base = 0; prev_addr = 0;
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; wb_mode = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    check(cpu_stall == 0, "R1", "stall after reset", {31'd0, cpu_stall}, 0);
    check(mem_valid == 0, "R1", "no beat after reset", {31'd0, mem_valid}, 0);
    check(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
          {hit_count, miss_count}, 0);

    // address split: 1200 -> line 11; 1204 same line; 2224 aliases it
    access(0, 32'd1200, 0, 1);
    check(miss_count == 1, "R1", "first access misses", {16'd0, miss_count}, 1);
    h0 = hit_count;
    access(0, 32'd1204, 0, 1);
    check(hit_count == 16'(h0 + 1), "R2", "same line hits", {16'd0, hit_count}, h0 + 1);
    m0 = miss_count;
    access(0, 32'd2224, 0, 1);
    check(miss_count == 16'(m0 + 1), "R2", "alias of line 11 misses", {16'd0, miss_count}, m0 + 1);
    access(0, 32'd1200, 0, 1);

    // write-back hit, then dirty eviction
    access(1, 32'd1200, 32'hDEAD0001, 1);
    access(0, 32'd1200, 0, 1);
    access(0, 32'd2224, 0, 1);
    access(0, 32'd1200, 0, 1);

    // write-back allocate on a write miss, then one miss counted
    access(1, 32'd3000, 32'hCAFE0002, 1);
    access(0, 32'd3000, 0, 1);

    // write-through hit, write-through miss without allocation
    access(1, 32'd1204, 32'h1111AAAA, 0);
    access(0, 32'd1204, 0, 1);
    access(1, 32'd5000, 32'h2222BBBB, 0);
    access(0, 32'd5000, 0, 1);

    // write-through hit on a line left dirty by write-back, then eviction
    access(1, 32'd3004, 32'h3333CCCC, 0);
    access(0, 32'd3000 + 32'd1024, 0, 1);
    access(0, 32'd3000, 0, 1);

    // random mix with a stalling memory
    rdy_rand = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = ($urandom % 4) * 1024 + ($urandom % 4 + 8) * 16 + ($urandom % 4) * 4;
      access(1'($urandom % 2), a, $urandom, 1'($urandom % 2));
    end
    finish_run();
  end
endmodule